// File: doc/BRIEF.md
# Zero-Address Stack Execution Unit

This block executes stack-machine instructions against an internal operand stack and a small internal data memory. Arithmetic instructions name no operand at all: each one takes the two entries nearest the top of the stack and replaces them with one result. Only the two memory-transfer instructions carry an address. A load copies a memory word onto the stack, and a store moves the top entry out to memory. The stack pointer moves on its own with every instruction that grows or shrinks the stack.

A controller hands over one instruction at a time through a valid/ready handshake. Every instruction takes the same fixed time. The unit reports the top entry, the entry count, empty and full indications, and two sticky error flags. A separate write port lets the environment load the data memory before a program runs. An expression is evaluated by issuing its postfix form. For example, the product of two sums is formed by two loads, an add, two more loads, an add, a multiply and a store.

Top module: `zstack_exec_unit`

## Requirements
- R1: After synchronous reset the stack holds no entries: stack_count is 0, stack_empty is 1, stack_full is 0, tos_data is 0, both error flags are 0 and instr_ready is 1.
- R2: An instruction is taken on a rising edge where instr_valid and instr_ready are both 1. instr_ready is then 0 for exactly one cycle, and the instruction's effect on every output is visible once instr_ready returns to 1.
- R3: Opcode 3'b000 (load) reads the data memory word at instr_addr and places it on top of the stack, raising stack_count by one.
- R4: Opcode 3'b001 (store) writes the top entry to the data memory word at instr_addr and removes it from the stack, lowering stack_count by one.
- R5: Opcode 3'b010 (add) replaces the two topmost entries with their sum modulo 2^DATA_W, lowering stack_count by one.
- R6: Opcode 3'b011 (subtract) replaces the two topmost entries with (entry below top − top entry) modulo 2^DATA_W.
- R7: Opcode 3'b100 (multiply) replaces the two topmost entries with the low DATA_W bits of their product.
- R8: An add, subtract or multiply issued with fewer than two entries, or a store issued with none, sets err_underflow and leaves the stack and the memory unchanged. err_underflow stays set until reset.
- R9: A load issued while the stack holds STACK_DEPTH entries sets err_overflow and changes nothing else. err_overflow stays set until reset.
- R10: Opcodes 3'b101, 3'b110 and 3'b111 change neither the stack, nor the memory, nor the error flags.
- R11: When pre_we is 1 at a rising edge, pre_data is written to the data memory word at pre_addr.
- R12: The sequence load A, load B, add, load C, load D, add, multiply, store X leaves ((A+B)·(C+D)) mod 2^DATA_W in word X and an empty stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | An instruction is offered |
| instr_ready | output | 1 | The unit can accept an instruction |
| instr_op | input | 3 | Opcode |
| instr_addr | input | $clog2(MEM_WORDS) | Memory address for load and store; ignored otherwise |
| pre_we | input | 1 | Memory preload write enable |
| pre_addr | input | $clog2(MEM_WORDS) | Memory preload address |
| pre_data | input | DATA_W | Memory preload data |
| tos_data | output | DATA_W | Top stack entry, 0 when empty |
| stack_count | output | $clog2(STACK_DEPTH+1) | Number of stack entries |
| stack_empty | output | 1 | Stack holds no entries |
| stack_full | output | 1 | Stack holds STACK_DEPTH entries |
| err_underflow | output | 1 | Sticky underflow error |
| err_overflow | output | 1 | Sticky overflow error |

## Verification
The bench sweeps operand pairs from zero to 255 through add, subtract and multiply. This catches a subtract with its operands swapped, which would return the negated difference, and a product that is not truncated or that keeps the wrong bits. It fills the stack to the last slot and then loads once more. A design with an off-by-one full test would either reject the eighth entry or overwrite a slot. It stores from an empty stack and runs arithmetic with zero and one entries. A design without these guards would wrap the count, write garbage to memory or leave the error flag clear. The unused opcodes are issued mid-program, and the bench then checks that the stack, the flags and the memory are unchanged.

// File: rtl/zs_pkg.sv
package zs_pkg;

    localparam logic [2:0] OPC_LOAD  = 3'd0;
    localparam logic [2:0] OPC_STORE = 3'd1;
    localparam logic [2:0] OPC_ADD   = 3'd2;
    localparam logic [2:0] OPC_SUB   = 3'd3;
    localparam logic [2:0] OPC_MUL   = 3'd4;

    typedef enum logic [1:0] {
        SC_HOLD = 2'd0,
        SC_PUSH = 2'd1,
        SC_POP  = 2'd2,
        SC_FOLD = 2'd3
    } stack_cmd_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EXEC = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic underflow;
        logic overflow;
    } err_flags_t;

    function automatic logic is_arith(input logic [2:0] opc);
        return (opc == OPC_ADD) || (opc == OPC_SUB) || (opc == OPC_MUL);
    endfunction

    // The operands arrive zero-extended; the caller keeps the low bits, which are
    // correct modulo 2^width for sum, difference and product alike.
    function automatic logic [31:0] alu_calc(input logic [2:0] opc,
                                             input logic [31:0] lhs,
                                             input logic [31:0] rhs);
        logic [31:0] res;
        case (opc)
            OPC_ADD: res = lhs + rhs;
            OPC_SUB: res = lhs - rhs;
            OPC_MUL: res = lhs * rhs;
            default: res = lhs;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/zs_data_mem.sv
module zs_data_mem #(
    parameter int DATA_W = 8,
    parameter int WORDS  = 16,
    localparam int ADDR_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data
);

    logic [DATA_W-1:0] word_q [WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            word_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = word_q[rd_addr];

endmodule

// File: rtl/zs_operand_stack.sv
module zs_operand_stack
    import zs_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  stack_cmd_e        cmd,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] top,
    output logic [DATA_W-1:0] second,
    output logic [CNT_W-1:0]  count,
    output logic              empty,
    output logic              full
);

    logic [DATA_W-1:0] slot_q [DEPTH];
    logic [CNT_W-1:0]  count_q;
    logic [DEPTH-1:0]  slot_we;
    logic [IDX_W-1:0]  top_idx;
    logic [IDX_W-1:0]  sec_idx;

    assign empty = (count_q == '0);
    assign full  = (count_q == CNT_W'(DEPTH));

    // A push lands in the slot just above the top; a fold overwrites the slot below it.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot_we
        assign slot_we[g] = ((cmd == SC_PUSH) && !full && (count_q == CNT_W'(g)))
                          || ((cmd == SC_FOLD) && (count_q == CNT_W'(g + 2)));
    end

    always_ff @(posedge clk) begin
        for (int g = 0; g < DEPTH; g++) begin
            if (slot_we[g]) begin
                slot_q[g] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else begin
            case (cmd)
                SC_PUSH: if (!full)                    count_q <= count_q + 1'b1;
                SC_POP:  if (!empty)                   count_q <= count_q - 1'b1;
                SC_FOLD: if (count_q >= CNT_W'(2))     count_q <= count_q - 1'b1;
                default: ;
            endcase
        end
    end

    assign top_idx = IDX_W'(count_q - CNT_W'(1));
    assign sec_idx = IDX_W'(count_q - CNT_W'(2));
    assign top     = empty ? '0 : slot_q[top_idx];
    assign second  = (count_q < CNT_W'(2)) ? '0 : slot_q[sec_idx];
    assign count   = count_q;

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        count_q <= CNT_W'(DEPTH)); // R9

    AST_PUSH_STEP: assert property (@(posedge clk) disable iff (rst)
        (cmd == SC_PUSH && !full) |=> (count_q == $past(count_q) + 1'b1)); // R3

    AST_FOLD_STEP: assert property (@(posedge clk) disable iff (rst)
        (cmd == SC_FOLD && count_q >= CNT_W'(2)) |=> (count_q == $past(count_q) - 1'b1)); // R5

endmodule

// File: rtl/zs_sequencer.sv
module zs_sequencer
    import zs_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    output logic              instr_ready,
    input  logic [2:0]        instr_op,
    input  logic [ADDR_W-1:0] instr_addr,
    input  logic [DATA_W-1:0] stk_top,
    input  logic [DATA_W-1:0] stk_second,
    input  logic [CNT_W-1:0]  stk_count,
    input  logic              stk_empty,
    input  logic              stk_full,
    output stack_cmd_e        stk_cmd,
    output logic [DATA_W-1:0] stk_wr_data,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wr_data,
    output err_flags_t        err
);

    seq_state_e        state_q;
    logic [2:0]        op_q;
    logic [ADDR_W-1:0] addr_q;
    err_flags_t        err_q;
    logic              ufl_set;
    logic              ovf_set;
    logic [DATA_W-1:0] alu_res;

    assign instr_ready = (state_q == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= '0;
            addr_q  <= '0;
        end else if (state_q == ST_IDLE) begin
            if (instr_valid) begin
                state_q <= ST_EXEC;
                op_q    <= instr_op;
                addr_q  <= instr_addr;
            end
        end else begin
            state_q <= ST_IDLE;
        end
    end

    assign alu_res = DATA_W'(alu_calc(op_q, 32'(stk_second), 32'(stk_top)));

    always_comb begin
        stk_cmd     = SC_HOLD;
        stk_wr_data = '0;
        mem_we      = 1'b0;
        mem_wr_data = stk_top;
        ufl_set     = 1'b0;
        ovf_set     = 1'b0;
        if (state_q == ST_EXEC) begin
            if (op_q == OPC_LOAD) begin
                if (stk_full) begin
                    ovf_set = 1'b1;
                end else begin
                    stk_cmd     = SC_PUSH;
                    stk_wr_data = mem_rd_data;
                end
            end else if (op_q == OPC_STORE) begin
                if (stk_empty) begin
                    ufl_set = 1'b1;
                end else begin
                    stk_cmd = SC_POP;
                    mem_we  = 1'b1;
                end
            end else if (is_arith(op_q)) begin
                if (stk_count < CNT_W'(2)) begin
                    ufl_set = 1'b1;
                end else begin
                    stk_cmd     = SC_FOLD;
                    stk_wr_data = alu_res;
                end
            end
        end
    end

    assign mem_addr = addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= '0;
        end else begin
            if (ufl_set) err_q.underflow <= 1'b1;
            if (ovf_set) err_q.overflow  <= 1'b1;
        end
    end

    assign err = err_q;

    AST_READY_GAP: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && instr_ready) |=> !instr_ready); // R2

    AST_READY_BACK: assert property (@(posedge clk) disable iff (rst)
        !instr_ready |=> instr_ready); // R2

    AST_UFL_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_q.underflow |=> err_q.underflow); // R8

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_q.overflow |=> err_q.overflow); // R9

endmodule

// File: rtl/zstack_exec_unit.sv
module zstack_exec_unit
    import zs_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int STACK_DEPTH = 8,
    parameter int MEM_WORDS   = 16
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               instr_valid,
    output logic                               instr_ready,
    input  logic [2:0]                         instr_op,
    input  logic [$clog2(MEM_WORDS)-1:0]       instr_addr,
    input  logic                               pre_we,
    input  logic [$clog2(MEM_WORDS)-1:0]       pre_addr,
    input  logic [DATA_W-1:0]                  pre_data,
    output logic [DATA_W-1:0]                  tos_data,
    output logic [$clog2(STACK_DEPTH+1)-1:0]   stack_count,
    output logic                               stack_empty,
    output logic                               stack_full,
    output logic                               err_underflow,
    output logic                               err_overflow
);

    localparam int ADDR_W = $clog2(MEM_WORDS);
    localparam int CNT_W  = $clog2(STACK_DEPTH + 1);

    stack_cmd_e        stk_cmd;
    logic [DATA_W-1:0] stk_wr_data;
    logic [DATA_W-1:0] stk_top;
    logic [DATA_W-1:0] stk_second;
    logic [CNT_W-1:0]  stk_count;
    logic              stk_empty;
    logic              stk_full;
    logic [ADDR_W-1:0] seq_addr;
    logic              seq_we;
    logic [DATA_W-1:0] seq_wr_data;
    logic [DATA_W-1:0] mem_rd_data;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_wr_addr;
    logic [DATA_W-1:0] mem_wr_data;
    err_flags_t        err;

    zs_sequencer #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .instr_valid (instr_valid),
        .instr_ready (instr_ready),
        .instr_op    (instr_op),
        .instr_addr  (instr_addr),
        .stk_top     (stk_top),
        .stk_second  (stk_second),
        .stk_count   (stk_count),
        .stk_empty   (stk_empty),
        .stk_full    (stk_full),
        .stk_cmd     (stk_cmd),
        .stk_wr_data (stk_wr_data),
        .mem_addr    (seq_addr),
        .mem_rd_data (mem_rd_data),
        .mem_we      (seq_we),
        .mem_wr_data (seq_wr_data),
        .err         (err)
    );

    zs_operand_stack #(
        .DATA_W (DATA_W),
        .DEPTH  (STACK_DEPTH)
    ) u_stack (
        .clk     (clk),
        .rst     (rst),
        .cmd     (stk_cmd),
        .wr_data (stk_wr_data),
        .top     (stk_top),
        .second  (stk_second),
        .count   (stk_count),
        .empty   (stk_empty),
        .full    (stk_full)
    );

    // A store from the executing instruction wins over a preload in the same cycle.
    assign mem_we      = seq_we | pre_we;
    assign mem_wr_addr = seq_we ? seq_addr    : pre_addr;
    assign mem_wr_data = seq_we ? seq_wr_data : pre_data;

    zs_data_mem #(
        .DATA_W (DATA_W),
        .WORDS  (MEM_WORDS)
    ) u_mem (
        .clk     (clk),
        .rd_addr (seq_addr),
        .rd_data (mem_rd_data),
        .wr_en   (mem_we),
        .wr_addr (mem_wr_addr),
        .wr_data (mem_wr_data)
    );

    assign tos_data      = stk_top;
    assign stack_count   = stk_count;
    assign stack_empty   = stk_empty;
    assign stack_full    = stk_full;
    assign err_underflow = err.underflow;
    assign err_overflow  = err.overflow;

    AST_UFL_FREEZE: assert property (@(posedge clk) disable iff (rst)
        $rose(err_underflow) |-> $stable(stack_count)); // R8

    AST_OVF_FREEZE: assert property (@(posedge clk) disable iff (rst)
        $rose(err_overflow) |-> $stable(stack_count)); // R9

    AST_EMPTY_TOS: assert property (@(posedge clk) disable iff (rst)
        stack_empty |-> (tos_data == '0)); // R1

endmodule

// File: tb/sim_zstack_exec_unit.sv
module sim_zstack_exec_unit;

    localparam int DW = 8;
    localparam int SD = 8;
    localparam int MW = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       instr_valid = 1'b0;
    logic       instr_ready;
    logic [2:0] instr_op = '0;
    logic [3:0] instr_addr = '0;
    logic       pre_we = 1'b0;
    logic [3:0] pre_addr = '0;
    logic [7:0] pre_data = '0;
    logic [7:0] tos_data;
    logic [3:0] stack_count;
    logic       stack_empty;
    logic       stack_full;
    logic       err_underflow;
    logic       err_overflow;

    int checks = 0;
    int errors = 0;

    int mstk [SD];
    int mcnt = 0;
    int mmem [MW];
    int mufl = 0;
    int movf = 0;

    always #5 clk = ~clk;

    zstack_exec_unit #(.DATA_W(DW), .STACK_DEPTH(SD), .MEM_WORDS(MW)) u0 (
        .clk (clk), .rst (rst),
        .instr_valid (instr_valid), .instr_ready (instr_ready),
        .instr_op (instr_op), .instr_addr (instr_addr),
        .pre_we (pre_we), .pre_addr (pre_addr), .pre_data (pre_data),
        .tos_data (tos_data), .stack_count (stack_count),
        .stack_empty (stack_empty), .stack_full (stack_full),
        .err_underflow (err_underflow), .err_overflow (err_overflow)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_apply(input int op, input int addr);
        int a, b, r;
        case (op)
            0: if (mcnt == SD) movf = 1;
               else begin mstk[mcnt] = mmem[addr]; mcnt++; end
            1: if (mcnt == 0) mufl = 1;
               else begin mmem[addr] = mstk[mcnt-1]; mcnt--; end
            2, 3, 4: if (mcnt < 2) mufl = 1;
               else begin
                   a = mstk[mcnt-2];
                   b = mstk[mcnt-1];
                   r = (op == 2) ? a + b : (op == 3) ? a - b : a * b;
                   mstk[mcnt-2] = r & 255;
                   mcnt--;
               end
            default: ;
        endcase
    endtask

    task automatic check_state(input string req);
        chk(req, int'(instr_ready), 1);
        chk(req, int'(stack_count), mcnt);
        chk(req, int'(tos_data), (mcnt > 0) ? mstk[mcnt-1] : 0);
        chk(req, int'(stack_empty), (mcnt == 0) ? 1 : 0);
        chk(req, int'(stack_full), (mcnt == SD) ? 1 : 0);
        chk(req, int'(err_underflow), mufl);
        chk(req, int'(err_overflow), movf);
    endtask

    task automatic issue(input int op, input int addr, input string req);
        @(negedge clk);
        while (!instr_ready) @(negedge clk);
        instr_valid = 1'b1;
        instr_op    = 3'(op);
        instr_addr  = 4'(addr);
        @(posedge clk);
        @(negedge clk);
        chk("R2", int'(instr_ready), 0);
        instr_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        model_apply(op, addr);
        check_state(req);
    endtask

    task automatic preload(input int addr, input int data);
        @(negedge clk);
        pre_we   = 1'b1;
        pre_addr = 4'(addr);
        pre_data = 8'(data);
        @(posedge clk);
        @(negedge clk);
        pre_we = 1'b0;
        mmem[addr] = data & 255;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        mcnt = 0;
        mufl = 0;
        movf = 0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: state right after reset
        chk("R1", int'(stack_count), 0);
        chk("R1", int'(stack_empty), 1);
        chk("R1", int'(stack_full), 0);
        chk("R1", int'(tos_data), 0);
        chk("R1", int'(err_underflow), 0);
        chk("R1", int'(err_overflow), 0);
        chk("R1", int'(instr_ready), 1);

        // R11 preload, R3 loads up to full
        for (int i = 0; i < MW; i++) preload(i, (i * 37 + 11) & 255);
        for (int i = 0; i < SD; i++) issue(0, i, "R3");
        // R9 load on full stack
        issue(0, 8, "R9");
        // R10 unused opcodes, memory word 9 re-read later
        issue(5, 9, "R10");
        issue(6, 9, "R10");
        issue(7, 9, "R10");
        // R4 stores to words 15..8
        for (int i = 0; i < SD; i++) issue(1, 15 - i, "R4");
        // R8 store on empty stack; memory word 3 must keep its value
        issue(1, 3, "R8");
        for (int i = 0; i < SD; i++) issue(0, 8 + i, "R4");
        for (int i = 0; i < SD; i++) issue(1, 8 + i, "R4");
        issue(0, 3, "R8");
        issue(1, 3, "R4");

        // R8 arithmetic underflow with 0 and 1 entries
        do_reset();
        chk("R1", int'(stack_count), 0);
        issue(2, 0, "R8");
        issue(0, 0, "R3");
        issue(3, 0, "R8");
        issue(4, 0, "R8");
        issue(7, 0, "R10");
        issue(1, 0, "R4");

        // R5 R6 R7 operand sweep
        do_reset();
        for (int a = 0; a < 256; a += 17) begin
            for (int b = 0; b < 256; b += 19) begin
                preload(0, a);
                preload(1, b);
                issue(0, 0, "R3");
                issue(0, 1, "R3");
                issue(2, 0, "R5");
                issue(0, 1, "R3");
                issue(3, 0, "R6");
                issue(0, 1, "R3");
                issue(4, 0, "R7");
                issue(1, 2, "R4");
            end
        end
        preload(0, 255);
        preload(1, 255);
        issue(0, 0, "R3");
        issue(0, 1, "R3");
        issue(4, 0, "R7");
        chk("R7", int'(tos_data), (255 * 255) & 255);
        issue(1, 2, "R4");

        // R12 expression (A+B)*(C+D) stored to X
        do_reset();
        preload(4, 23);
        preload(5, 9);
        preload(6, 200);
        preload(7, 77);
        issue(0, 4, "R12");
        issue(0, 5, "R12");
        issue(2, 0, "R12");
        issue(0, 6, "R12");
        issue(0, 7, "R12");
        issue(2, 0, "R12");
        issue(4, 0, "R12");
        issue(1, 10, "R12");
        chk("R12", int'(stack_count), 0);
        issue(0, 10, "R12");
        chk("R12", int'(tos_data), ((23 + 9) * ((200 + 77) & 255)) & 255);

        finish_run();
    end

endmodule